// File: doc/BRIEF.md
# Keyed Watchdog Timer with Exponent Select

This block is a watchdog timer with a small register port. Supervisory software configures it through one 16-bit control register. That register accepts a new value only after a two-word unlock key has been written to it. A second, separate two-word key written to the same register restarts the count. Software that stops sending the restart key lets the counter run up to a power-of-two limit. When the count reaches that limit, the block sets a sticky interrupt flag and, if reset on expiry is enabled, pulses a reset request to the system reset logic.

The timeout is chosen with a one-hot exponent field rather than a loadable reload value. One short setting is provided for fast checks, and seven long settings each double the one before. The running count can be read as a low and a high 16-bit half. The exponents behind the short setting and the first long setting are parameters, so a simulation build can use short limits. The defaults give 2^14 ticks for the short setting and 2^24 through 2^30 ticks for the long ones, with one tick per clock.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, the control readback, both count halves, `irq_flag` and `rst_req` are all zero.
- R2: A write to the control address (`wr_addr` 0) changes no configuration unless the two writes before it on that address were 0x3333 and then 0xCCCC. The key words themselves are not stored.
- R3: The single write that follows an unlock loads enable from bit 15, reset-on-expiry from bit 14 and the exponent select from bits 7:0. The lock then closes again. The control readback places the same fields at the same bits, shows the flag at bit 12 and reads zero at bits 13 and 11:8.
- R4: If the write after 0x3333 is not 0xCCCC, the key logic returns to idle, and the word that broke the sequence is neither loaded nor taken as a key.
- R5: While enabled, the count rises by one every clock. While disabled, it holds its value.
- R6: Exponent bit 0 gives a timeout of 2^EXP_SHORT clocks. Exponent bit i (for i from 1 to 7) gives 2^(EXP_BASE+i-1) clocks. On expiry the count returns to zero and `irq_flag` sets, whatever the reset-enable bit holds.
- R7: On expiry, `rst_req` is high for exactly one clock, and only when bit 14 is set.
- R8: Writing 0xAAAA and then 0x5555 to the control address sets the count to zero.
- R9: If the write after 0xAAAA is not 0x5555, the count is not restarted and the breaking word has no other effect.
- R10: An unlocked control write with bit 12 set clears `irq_flag`. An unlocked write with bit 12 clear leaves the flag as it was.
- R11: If the exponent field is zero or has more than one bit set, the timer never expires and `irq_flag` never sets.
- R12: `rd_addr` 1 returns count bits 15:0 and `rd_addr` 2 returns count bits 31:16. Writes to addresses 1 and 2 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one count tick per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per asserted cycle |
| wr_addr | input | 2 | Write address: 0 control, 1 and 2 read-only |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address: 0 control, 1 count low, 2 count high |
| rd_data | output | 16 | Combinational read data |
| irq_flag | output | 1 | Sticky expiry flag, the same bit as control bit 12 |
| rst_req | output | 1 | One-clock reset request on expiry |

## Verification
A write is driven on a falling edge and takes effect at the next rising edge. Reads are combinational, so the bench samples every result one falling edge after a stimulus, at a point where each register has settled. After the write that enables the timer or restarts it, the count reads N once N more falling edges have passed. With a limit of L, the flag and the reset pulse must therefore still be low after L-1 edges and high after L edges. One edge later the pulse must be gone. The bench tests each of these neighbouring cycles directly, so an error of one clock in the limit or in the pulse length shows up in a check.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
   localparam int REG_W = 16;
   localparam int EXP_W = 8;

   localparam int BIT_EN     = 15;
   localparam int BIT_RSTEN  = 14;
   localparam int BIT_FLAG   = 12;

   localparam logic [REG_W-1:0] KEY_OPEN_1 = 16'h3333;
   localparam logic [REG_W-1:0] KEY_OPEN_2 = 16'hCCCC;
   localparam logic [REG_W-1:0] KEY_KICK_1 = 16'hAAAA;
   localparam logic [REG_W-1:0] KEY_KICK_2 = 16'h5555;

   localparam logic [1:0] ADR_CTRL   = 2'd0;
   localparam logic [1:0] ADR_CNT_LO = 2'd1;
   localparam logic [1:0] ADR_CNT_HI = 2'd2;

   typedef enum logic [1:0] {
      KS_IDLE      = 2'd0,
      KS_OPEN_HALF = 2'd1,
      KS_OPEN      = 2'd2,
      KS_KICK_HALF = 2'd3
   } key_state_e;

   function automatic int exp_of(input int idx, input int short_e, input int base_e);
      return (idx == 0) ? short_e : base_e + idx - 1;
   endfunction
endpackage

// File: rtl/wdk_keyseq.sv
module wdk_keyseq
   import wdk_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_wr,
   input  logic [REG_W-1:0] wdata,
   output logic             cfg_load,
   output logic             kick,
   output key_state_e       state
);
   key_state_e nxt;

   always_comb begin
      nxt      = state;
      cfg_load = 1'b0;
      kick     = 1'b0;
      if (ctrl_wr) begin
         unique case (state)
            KS_IDLE: begin
               if (wdata == KEY_OPEN_1)      nxt = KS_OPEN_HALF;
               else if (wdata == KEY_KICK_1) nxt = KS_KICK_HALF;
            end
            KS_OPEN_HALF: nxt = (wdata == KEY_OPEN_2) ? KS_OPEN : KS_IDLE;
            KS_OPEN: begin
               cfg_load = 1'b1;
               nxt      = KS_IDLE;
            end
            KS_KICK_HALF: begin
               kick = (wdata == KEY_KICK_2);
               nxt  = KS_IDLE;
            end
            default: nxt = KS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= KS_IDLE;
      else        state <= nxt;
   end
endmodule

// File: rtl/wdk_cfg_reg.sv
module wdk_cfg_reg
   import wdk_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_load,
   input  logic [REG_W-1:0] wdata,
   input  logic             expire,
   output logic             en,
   output logic             rst_en,
   output logic [EXP_W-1:0] exp_sel,
   output logic             flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en      <= 1'b0;
         rst_en  <= 1'b0;
         exp_sel <= '0;
      end else if (cfg_load) begin
         en      <= wdata[BIT_EN];
         rst_en  <= wdata[BIT_RSTEN];
         exp_sel <= wdata[EXP_W-1:0];
      end
   end

   // expiry wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          flag <= 1'b0;
      else if (expire)                     flag <= 1'b1;
      else if (cfg_load && wdata[BIT_FLAG]) flag <= 1'b0;
   end
endmodule

// File: rtl/wdk_counter.sv
module wdk_counter
   import wdk_pkg::*;
#(
   parameter int CNT_W     = 32,
   parameter int EXP_SHORT = 14,
   parameter int EXP_BASE  = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             kick,
   input  logic [EXP_W-1:0] exp_sel,
   output logic [CNT_W-1:0] count,
   output logic             expire
);
   logic [EXP_W-1:0] reach;
   logic             sel_ok;

   for (genvar i = 0; i < EXP_W; i++) begin : g_term
      localparam int E = exp_of(i, EXP_SHORT, EXP_BASE);
      localparam logic [CNT_W-1:0] TERM = CNT_W'((64'd1 << E) - 64'd1);
      assign reach[i] = (count >= TERM);
   end

   assign sel_ok = (exp_sel != '0) && ((exp_sel & (exp_sel - 1'b1)) == '0);
   assign expire = en && sel_ok && (|(exp_sel & reach));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              count <= '0;
      else if (kick || expire) count <= '0;
      else if (en)             count <= count + 1'b1;
   end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
   import wdk_pkg::*;
#(
   parameter int CNT_W     = 32,
   parameter int EXP_SHORT = 14,
   parameter int EXP_BASE  = 24
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [1:0]  wr_addr,
   input  logic [15:0] wr_data,
   input  logic [1:0]  rd_addr,
   output logic [15:0] rd_data,
   output logic        irq_flag,
   output logic        rst_req
);
   localparam int TOP_E = EXP_BASE + EXP_W - 2;

   if (EXP_SHORT < 1 || EXP_SHORT >= EXP_BASE) begin : g_bad_exp
      $error("keyed_wdt: EXP_SHORT must be at least 1 and below EXP_BASE");
   end
   if (CNT_W < TOP_E || CNT_W > 2 * REG_W) begin : g_bad_cnt
      $error("keyed_wdt: CNT_W must cover the longest limit and fit two read halves");
   end

   logic             ctrl_wr, cfg_load, kick, expire;
   key_state_e       key_state;
   logic             cfg_en, cfg_rst_en;
   logic [EXP_W-1:0] cfg_exp;
   logic [CNT_W-1:0] count_q;
   logic [2*REG_W-1:0] cnt_ext;

   assign ctrl_wr = wr_en && (wr_addr == ADR_CTRL);

   wdk_keyseq u_keys (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl_wr  (ctrl_wr),
      .wdata    (wr_data),
      .cfg_load (cfg_load),
      .kick     (kick),
      .state    (key_state)
   );

   wdk_cfg_reg u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_load (cfg_load),
      .wdata    (wr_data),
      .expire   (expire),
      .en       (cfg_en),
      .rst_en   (cfg_rst_en),
      .exp_sel  (cfg_exp),
      .flag     (irq_flag)
   );

   wdk_counter #(
      .CNT_W     (CNT_W),
      .EXP_SHORT (EXP_SHORT),
      .EXP_BASE  (EXP_BASE)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (cfg_en),
      .kick    (kick),
      .exp_sel (cfg_exp),
      .count   (count_q),
      .expire  (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_req <= 1'b0;
      else        rst_req <= expire && cfg_rst_en;
   end

   assign cnt_ext = (2*REG_W)'(count_q);

   always_comb begin
      rd_data = '0;
      unique case (rd_addr)
         ADR_CTRL: begin
            rd_data[BIT_EN]      = cfg_en;
            rd_data[BIT_RSTEN]   = cfg_rst_en;
            rd_data[BIT_FLAG]    = irq_flag;
            rd_data[EXP_W-1:0]   = cfg_exp;
         end
         ADR_CNT_LO: rd_data = cnt_ext[REG_W-1:0];
         ADR_CNT_HI: rd_data = cnt_ext[2*REG_W-1:REG_W];
         default:    rd_data = '0;
      endcase
   end
endmodule

// File: rtl/wdk_checker.sv
module wdk_checker
   import wdk_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       wr_addr,
   input key_state_e       key_state,
   input logic             cfg_en,
   input logic             cfg_rst_en,
   input logic [EXP_W-1:0] cfg_exp,
   input logic [CNT_W-1:0] count_q,
   input logic             irq_flag,
   input logic             rst_req
);
   logic ctrl_wr;
   assign ctrl_wr = wr_en && (wr_addr == ADR_CTRL);

   AST_LOCKED_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && key_state != KS_OPEN) |=> $stable({cfg_en, cfg_rst_en, cfg_exp})); // R2

   AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_en && !ctrl_wr) |=> $stable(count_q)); // R5

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_en && !ctrl_wr) |=> (count_q == $past(count_q) + 1'b1 || count_q == '0)); // R5

   AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req); // R7

   AST_RST_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> irq_flag); // R7

   AST_RST_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_rst_en && !ctrl_wr) |=> !rst_req); // R7

   AST_BAD_EXP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (!$onehot(cfg_exp)) |=> !$rose(irq_flag)); // R11
endmodule

bind keyed_wdt wdk_checker #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .key_state  (key_state),
   .cfg_en     (cfg_en),
   .cfg_rst_en (cfg_rst_en),
   .cfg_exp    (cfg_exp),
   .count_q    (count_q),
   .irq_flag   (irq_flag),
   .rst_req    (rst_req)
);

// File: tb/keyed_wdt_tb.sv
`timescale 1ns/1ps
module keyed_wdt_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [1:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic        irq_flag, rst_req;
   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   keyed_wdt #(.CNT_W(32), .EXP_SHORT(4), .EXP_BASE(6)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .irq_flag(irq_flag), .rst_req(rst_req)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic chk_eq(input string tag, input int act, input int exp);
      check(act == exp, tag, act, exp);
   endtask

   task automatic do_reset();
      wr_en = 1'b0;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int d);
      rd_addr = a;
      #1;
      d = int'(rd_data);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic unlock_write(input logic [15:0] d);
      wr(2'd0, 16'h3333);
      wr(2'd0, 16'hCCCC);
      wr(2'd0, d);
   endtask

   task automatic t_reset();
      int v;
      do_reset();
      rd(2'd0, v); chk_eq("R1 ctrl", v, 0);
      rd(2'd1, v); chk_eq("R1 cnt_lo", v, 0);
      rd(2'd2, v); chk_eq("R1 cnt_hi", v, 0);
      chk_eq("R1 irq_flag", int'(irq_flag), 0);
      chk_eq("R1 rst_req", int'(rst_req), 0);
   endtask

   task automatic t_locked();
      int v;
      do_reset();
      wr(2'd0, 16'h8001);
      idle(5);
      rd(2'd0, v); chk_eq("R2 plain write ignored", v, 0);
      rd(2'd1, v); chk_eq("R2 counter still off", v, 0);
      wr(2'd0, 16'hCCCC);
      wr(2'd0, 16'h8001);
      rd(2'd0, v); chk_eq("R2 second key alone", v, 0);
   endtask

   task automatic t_broken_unlock();
      int v;
      do_reset();
      wr(2'd0, 16'h3333);
      wr(2'd0, 16'h1234);
      wr(2'd0, 16'h8001);
      rd(2'd0, v); chk_eq("R4 broken unlock", v, 0);
      wr(2'd0, 16'h3333);
      wr(2'd0, 16'hAAAA);
      wr(2'd0, 16'h5555);
      wr(2'd0, 16'h8001);
      rd(2'd0, v); chk_eq("R4 breaking word not a key", v, 0);
   endtask

   task automatic t_unlock_and_count();
      int v;
      do_reset();
      unlock_write(16'hF0FF);
      rd(2'd0, v); chk_eq("R3 loaded fields", v, 16'hC0FF);
      wr(2'd0, 16'h0000);
      rd(2'd0, v); chk_eq("R3 relocked", v, 16'hC0FF);
      idle(9);
      rd(2'd1, v); chk_eq("R5 counting", v, 10);
      unlock_write(16'h0000);
      idle(5);
      rd(2'd1, v); chk_eq("R5 hold when disabled", v, 13);
   endtask

   task automatic t_expire_short();
      int v;
      do_reset();
      unlock_write(16'hC001);
      idle(15);
      chk_eq("R6 no flag before limit", int'(irq_flag), 0);
      chk_eq("R7 no pulse before limit", int'(rst_req), 0);
      rd(2'd1, v); chk_eq("R6 count before limit", v, 15);
      idle(1);
      chk_eq("R6 flag at 2^EXP_SHORT", int'(irq_flag), 1);
      chk_eq("R7 pulse at expiry", int'(rst_req), 1);
      rd(2'd1, v); chk_eq("R6 count wrapped", v, 0);
      idle(1);
      chk_eq("R7 pulse one cycle", int'(rst_req), 0);
   endtask

   task automatic t_expire_long(input logic [15:0] cfg, input int lim, input string tag);
      do_reset();
      unlock_write(cfg);
      idle(lim - 1);
      chk_eq({tag, " R6 quiet"}, int'(irq_flag), 0);
      idle(1);
      chk_eq({tag, " R6 flag"}, int'(irq_flag), 1);
      chk_eq({tag, " R7 no pulse without enable"}, int'(rst_req), 0);
   endtask

   task automatic t_flag_clear();
      int v;
      do_reset();
      unlock_write(16'h8001);
      idle(16);
      chk_eq("R10 flag set", int'(irq_flag), 1);
      unlock_write(16'h8001);
      chk_eq("R10 write 0 keeps flag", int'(irq_flag), 1);
      unlock_write(16'h9001);
      chk_eq("R10 write 1 clears", int'(irq_flag), 0);
      rd(2'd0, v); chk_eq("R10 readback", v, 16'h8001);
   endtask

   task automatic t_kick();
      int v;
      do_reset();
      unlock_write(16'h8002);
      idle(40);
      wr(2'd0, 16'hAAAA);
      wr(2'd0, 16'h5555);
      rd(2'd1, v); chk_eq("R8 count restarted", v, 0);
      rd(2'd0, v); chk_eq("R8 ctrl untouched", v, 16'h8002);
      idle(63);
      chk_eq("R8 quiet after restart", int'(irq_flag), 0);
      idle(1);
      chk_eq("R8 expiry from restart", int'(irq_flag), 1);
   endtask

   task automatic t_broken_kick();
      int v;
      do_reset();
      unlock_write(16'h8002);
      idle(10);
      wr(2'd0, 16'hAAAA);
      wr(2'd0, 16'h1111);
      wr(2'd0, 16'h5555);
      rd(2'd1, v); chk_eq("R9 no restart", v, 13);
      rd(2'd0, v); chk_eq("R9 ctrl untouched", v, 16'h8002);
   endtask

   task automatic t_invalid_and_read();
      int v;
      do_reset();
      unlock_write(16'h8003);
      idle(200);
      chk_eq("R11 two bits never expire", int'(irq_flag), 0);
      do_reset();
      unlock_write(16'h8000);
      idle(65541);
      chk_eq("R11 zero field never expires", int'(irq_flag), 0);
      rd(2'd1, v); chk_eq("R12 low half", v, 5);
      rd(2'd2, v); chk_eq("R12 high half", v, 1);
      wr(2'd1, 16'h0000);
      wr(2'd2, 16'h0000);
      rd(2'd1, v); chk_eq("R12 low write ignored", v, 7);
      rd(2'd2, v); chk_eq("R12 high write ignored", v, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_locked();
      t_broken_unlock();
      t_unlock_and_count();
      t_expire_short();
      t_expire_long(16'h8002, 64, "bit1");
      t_expire_long(16'h8080, 4096, "bit7");
      t_flag_clear();
      t_kick();
      t_broken_kick();
      t_invalid_and_read();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule